// File: doc/BRIEF.md
# Legacy Region Attribute Decoder

This block steers each memory access that falls in the 768 KB to 1 MB legacy window (0xC0000 to 0xFFFFF) either to DRAM or to memory-mapped I/O. The window is divided into thirteen regions: twelve 16 KB regions from 0xC0000 to 0xEFFFF and one 64 KB region from 0xF0000 to 0xFFFFF. Each region carries a 2-bit attribute code. One bit of the code routes reads and the other routes writes, so a region can send its reads to DRAM while its writes go to I/O, or the reverse. This lets a shadowing sequence copy ROM contents into DRAM before switching reads over.

The attribute codes live in seven byte-wide registers that are loaded through a simple write port and can be read back. An access is presented as an address, a direction and a valid strobe. The decision appears on registered outputs one clock later. Addresses outside the legacy window, including anything at or above 1 MB, produce neither select flag.

Top module: `legacy_attr_decoder`

## Requirements
- R1: After reset all seven attribute registers read back 0x00, and every legacy access, read or write, is routed to MMIO.
- R2: The attribute code gives the direction-specific routing: bit 0 set sends reads to DRAM, and bit 1 set sends writes to DRAM. So 00 sends all accesses to MMIO, 01 sends reads to DRAM and writes to MMIO, 10 sends writes to DRAM and reads to MMIO, and 11 sends all accesses to DRAM.
- R3: The 64 KB region 0xF0000 to 0xFFFFF is governed by bits 5:4 of register 0. Bits 7:6 and 3:0 of register 0 ignore writes and read back as zero.
- R4: The twelve 16 KB regions from 0xC0000 to 0xEFFFF are numbered s = 0..11 in ascending address order. Region s is governed by register 1 + s/2: bits 1:0 of that register when s is even, and bits 5:4 when s is odd.
- R5: In registers 1 to 6, bits 7:6 and 3:2 ignore writes and read back as zero. A write to register index 7 has no effect, and reading index 7 returns 0x00.
- R6: An access whose address lies outside 0xC0000 to 0xFFFFF, including any address with a bit set at or above bit 20, produces a valid result with both the DRAM and the MMIO select low.
- R7: An access sampled with `acc_valid` high at a clock edge produces `dec_valid` high and the routing on `dec_dram` and `dec_mmio` in the cycle after that edge. When `acc_valid` is low at an edge, all three outputs are low in the following cycle.
- R8: A register write takes effect at the clock edge that samples it. An access sampled at the same edge is routed using the old register value.
- R9: Writing 0x33 to one of registers 1 to 6 maps both of its regions fully to DRAM. Writing 0x30 to register 0 does the same for the top 64 KB.
- R10: For a valid access inside the legacy window, exactly one of `dec_dram` and `dec_mmio` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Attribute register write strobe |
| cfg_waddr | input | 3 | Register index for writes (0..6 valid) |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 3 | Register index for read-back |
| cfg_rdata | output | 8 | Read-back data, reserved bits zero |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Physical byte address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| dec_valid | output | 1 | Registered: a result is present |
| dec_dram | output | 1 | Registered: access routed to DRAM |
| dec_mmio | output | 1 | Registered: access routed to memory-mapped I/O |

## Verification
The bench builds the block with its default 32-bit address width. This makes the guard on the upper address bits reachable, so an access at 0x100000 and one far above 1 MB must both come out undecoded even though their low 20 bits alias into the window. It sweeps all twelve 16 KB regions and the top region under two different register patterns. It checks the four codes in both directions, and it lines up a register write and an access at the same edge to expose the old value.

// File: rtl/legacy_attr_pkg.sv
`timescale 1ns/1ps
package legacy_attr_pkg;

  localparam int unsigned ATTR_BYTE_W = 8;
  localparam int unsigned ATTR_IDX_W  = 3;
  localparam int unsigned ATTR_REGS   = 7;

  typedef struct packed {
    logic                  hit;
    logic [ATTR_IDX_W-1:0] idx;
    logic                  upper;
  } region_t;

  // Which register and which half govern a 20-bit window offset
  function automatic region_t locate(input logic [19:0] a20, input logic above_clear);
    region_t r;
    r = '0;
    if (a20[19:16] == 4'hF) begin
      r.hit   = above_clear;
      r.idx   = '0;
      r.upper = 1'b1;
    end else if (a20[19:18] == 2'b11) begin
      r.hit   = above_clear;
      r.idx   = ATTR_IDX_W'({1'b0, a20[17:15]}) + ATTR_IDX_W'(1);
      r.upper = a20[14];
    end
    return r;
  endfunction

  // Writable bits of each register; unused indices have none
  function automatic logic [ATTR_BYTE_W-1:0] field_mask(input int unsigned idx);
    if (idx == 0)              return 8'h30;
    else if (idx < ATTR_REGS)  return 8'h33;
    else                       return 8'h00;
  endfunction

  function automatic logic [1:0] pick_code(input logic [ATTR_BYTE_W-1:0] r, input logic upper);
    return upper ? r[5:4] : r[1:0];
  endfunction

  function automatic logic to_dram(input logic [1:0] code, input logic is_write);
    return is_write ? code[1] : code[0];
  endfunction

endpackage

// File: rtl/legacy_attr_regs.sv
`timescale 1ns/1ps
module legacy_attr_regs
  import legacy_attr_pkg::*;
#(
  parameter int unsigned NREGS = ATTR_REGS,
  localparam int unsigned FLAT_W = NREGS * ATTR_BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ATTR_IDX_W-1:0]  waddr,
  input  logic [ATTR_BYTE_W-1:0] wdata,
  input  logic [ATTR_IDX_W-1:0]  raddr,
  output logic [ATTR_BYTE_W-1:0] rdata,
  output logic [FLAT_W-1:0]      attr_flat
);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [ATTR_BYTE_W-1:0] q;
    logic                   sel;
    assign sel = we && (waddr == ATTR_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (sel) q <= wdata & field_mask(g);
    end
    assign attr_flat[g*ATTR_BYTE_W +: ATTR_BYTE_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (raddr == ATTR_IDX_W'(i)) rdata = attr_flat[i*ATTR_BYTE_W +: ATTR_BYTE_W];
    end
  end

  AST_RSVD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr == '0) |-> (rdata[3:0] == 4'h0 && rdata[7:6] == 2'b00)); // R3
  AST_RSVD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr != '0) |-> (rdata[7:6] == 2'b00 && rdata[3:2] == 2'b00)); // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == '0 && raddr == '0) |=> (rdata[5:4] == $past(wdata[5:4]))); // R8

endmodule

// File: rtl/legacy_attr_lookup.sv
`timescale 1ns/1ps
module legacy_attr_lookup
  import legacy_attr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREGS  = ATTR_REGS,
  localparam int unsigned FLAT_W = NREGS * ATTR_BYTE_W
) (
  input  logic [FLAT_W-1:0] attr_flat,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              hit,
  output logic [1:0]        code,
  output logic              dram_sel
);

  logic    above_clear;
  region_t reg_loc;

  if (ADDR_W > 20) begin : g_wide
    assign above_clear = (addr[ADDR_W-1:20] == '0);
  end else begin : g_narrow
    assign above_clear = 1'b1;
  end

  assign reg_loc = locate(addr[19:0], above_clear);
  assign hit     = reg_loc.hit;

  always_comb begin
    code = 2'b00;
    for (int i = 0; i < NREGS; i++) begin
      if (reg_loc.idx == ATTR_IDX_W'(i))
        code = pick_code(attr_flat[i*ATTR_BYTE_W +: ATTR_BYTE_W], reg_loc.upper);
    end
  end

  assign dram_sel = hit && to_dram(code, is_write);

endmodule

// File: rtl/legacy_attr_route.sv
`timescale 1ns/1ps
module legacy_attr_route (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_in,
  input  logic hit_in,
  input  logic dram_in,
  output logic dec_valid,
  output logic dec_dram,
  output logic dec_mmio
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_dram  <= 1'b0;
      dec_mmio  <= 1'b0;
    end else begin
      dec_valid <= valid_in;
      dec_dram  <= valid_in && hit_in && dram_in;
      dec_mmio  <= valid_in && hit_in && !dram_in;
    end
  end

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_dram && dec_mmio)); // R10
  AST_SEL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_dram || dec_mmio) |-> dec_valid); // R7

endmodule

// File: rtl/legacy_attr_decoder.sv
`timescale 1ns/1ps
module legacy_attr_decoder
  import legacy_attr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_waddr,
  input  logic [7:0]        cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              dec_valid,
  output logic              dec_dram,
  output logic              dec_mmio
);

  localparam int unsigned FLAT_W = ATTR_REGS * ATTR_BYTE_W;

  logic [FLAT_W-1:0] attr_flat;
  logic              lk_hit;
  logic [1:0]        lk_code;
  logic              lk_dram;

  legacy_attr_regs #(.NREGS(ATTR_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata),
    .attr_flat(attr_flat)
  );

  legacy_attr_lookup #(.ADDR_W(ADDR_W), .NREGS(ATTR_REGS)) u_lookup (
    .attr_flat(attr_flat), .addr(acc_addr), .is_write(acc_write),
    .hit(lk_hit), .code(lk_code), .dram_sel(lk_dram)
  );

  legacy_attr_route u_route (
    .clk(clk), .rst_n(rst_n),
    .valid_in(acc_valid), .hit_in(lk_hit), .dram_in(lk_dram),
    .dec_valid(dec_valid), .dec_dram(dec_dram), .dec_mmio(dec_mmio)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!dec_valid && !dec_dram && !dec_mmio)); // R7
  AST_OUTSIDE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !lk_hit) |=> (dec_valid && !dec_dram && !dec_mmio)); // R6
  AST_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && lk_hit && !acc_write) |=> (dec_dram == $past(lk_code[0]))); // R2
  AST_WRITE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && lk_hit && acc_write) |=> (dec_dram == $past(lk_code[1]))); // R2
  AST_HIT_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && lk_hit) |=> (dec_dram != dec_mmio)); // R10

endmodule

// File: tb/test_legacy_attr_decoder.sv
`timescale 1ns/1ps
module test_legacy_attr_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_waddr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [2:0]  cfg_raddr = '0;
  logic [7:0]  cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        dec_valid, dec_dram, dec_mmio;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [0:6];

  always #2 clk = ~clk;

  legacy_attr_decoder #(.ADDR_W(32)) i_legacy_attr_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .dec_valid(dec_valid), .dec_dram(dec_dram), .dec_mmio(dec_mmio)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 3'd7) model[idx] = d & ((idx == 3'd0) ? 8'h30 : 8'h33);
  endtask

  task automatic cfg_read(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk);
    cfg_raddr = idx;
    #1 d = cfg_rdata;
  endtask

  // returns {valid, dram, mmio}
  task automatic access(input logic [31:0] a, input logic wr, output logic [2:0] res);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr;
    @(negedge clk);
    res = {dec_valid, dec_dram, dec_mmio};
    acc_valid = 1'b0;
  endtask

  // independent expectation from the register model
  function automatic logic [2:0] expect_route(input logic [31:0] a, input logic wr);
    logic [1:0] code;
    int seg, r;
    if (a >= 32'hF0000 && a <= 32'hFFFFF) code = model[0][5:4];
    else if (a >= 32'hC0000 && a < 32'hF0000) begin
      seg = int'((a - 32'hC0000) / 32'h4000);
      r = 1 + seg / 2;
      code = (seg % 2 == 1) ? model[r][5:4] : model[r][1:0];
    end else return 3'b100;
    if ((wr && code[1]) || (!wr && code[0])) return 3'b110;
    return 3'b101;
  endfunction

  task automatic t_reset;
    logic [7:0] d; logic [2:0] res;
    for (int i = 0; i < 7; i++) begin
      cfg_read(3'(i), d);
      check("R1 reset readback", {24'd0, d}, 32'h0);
    end
    access(32'hF0000, 1'b0, res); check("R1 top read to mmio", {29'd0, res}, 32'b101);
    access(32'hC4000, 1'b1, res); check("R1 low write to mmio", {29'd0, res}, 32'b101);
  endtask

  task automatic t_codes;
    logic [2:0] res;
    for (int c = 0; c < 4; c++) begin
      cfg_write(3'd3, 8'(c));
      access(32'hD0010, 1'b0, res);
      check("R2 read routing", {29'd0, res}, {29'd0, (c[0] ? 3'b110 : 3'b101)});
      access(32'hD3FFC, 1'b1, res);
      check("R2 write routing", {29'd0, res}, {29'd0, (c[1] ? 3'b110 : 3'b101)});
    end
    cfg_write(3'd3, 8'h00);
  endtask

  task automatic t_top;
    logic [7:0] d; logic [2:0] res;
    cfg_write(3'd0, 8'hFF);
    cfg_read(3'd0, d); check("R3 reserved bits of top register", {24'd0, d}, 32'h30);
    cfg_write(3'd0, 8'h30);
    access(32'hF8000, 1'b0, res); check("R9 top read dram", {29'd0, res}, 32'b110);
    access(32'hFFFFF, 1'b1, res); check("R9 top write dram", {29'd0, res}, 32'b110);
    cfg_write(3'd0, 8'h1F);
    access(32'hF0004, 1'b0, res); check("R3 top code 01 read", {29'd0, res}, 32'b110);
    access(32'hF0004, 1'b1, res); check("R3 top code 01 write", {29'd0, res}, 32'b101);
    access(32'hEFFFF, 1'b0, res); check("R3 low bits do not steer 0xEC000 region", {29'd0, res}, 32'b101);
    cfg_write(3'd0, 8'h00);
  endtask

  task automatic t_sweep(input logic [7:0] seed);
    logic [2:0] res;
    for (int i = 1; i < 7; i++) cfg_write(3'(i), 8'(seed * i + 8'h5A * i));
    cfg_write(3'd0, seed);
    for (int s = 0; s < 13; s++) begin
      for (int w = 0; w < 2; w++) begin
        logic [31:0] a;
        a = (s < 12) ? (32'hC0000 + 32'(s) * 32'h4000 + 32'h1230) : 32'hF7777;
        access(a, w[0], res);
        check("R4 region sweep", {29'd0, res}, {29'd0, expect_route(a, w[0])});
      end
    end
  endtask

  task automatic t_reserved;
    logic [7:0] d; logic [2:0] res;
    for (int i = 1; i < 7; i++) begin
      cfg_write(3'(i), 8'hFF);
      cfg_read(3'(i), d);
      check("R5 reserved bits read zero", {24'd0, d}, 32'h33);
    end
    cfg_write(3'd7, 8'hFF);
    cfg_read(3'd7, d); check("R5 index 7 reads zero", {24'd0, d}, 32'h0);
    cfg_read(3'd6, d); check("R5 index 7 write leaves reg 6", {24'd0, d}, 32'h33);
    cfg_write(3'd5, 8'h33);
    access(32'hE0000, 1'b1, res); check("R9 0x33 lower write", {29'd0, res}, 32'b110);
    access(32'hE7FFF, 1'b0, res); check("R9 0x33 upper read", {29'd0, res}, 32'b110);
  endtask

  task automatic t_outside;
    logic [2:0] res;
    cfg_write(3'd0, 8'h30);
    access(32'hBFFFF, 1'b0, res);    check("R6 below window", {29'd0, res}, 32'b100);
    access(32'h100000, 1'b1, res);   check("R6 at 1MB", {29'd0, res}, 32'b100);
    access(32'h800F0000, 1'b0, res); check("R6 high alias", {29'd0, res}, 32'b100);
    access(32'h00000000, 1'b0, res); check("R6 zero address", {29'd0, res}, 32'b100);
  endtask

  task automatic t_timing;
    logic [2:0] res;
    access(32'hF0000, 1'b0, res);
    @(negedge clk);
    check("R7 idle after access", {29'd0, dec_valid, dec_dram, dec_mmio}, 32'b000);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'hF0000; acc_write = 1'b0;
    #1 check("R7 no combinational output", {29'd0, dec_valid, dec_dram, dec_mmio}, 32'b000);
    @(negedge clk);
    check("R7 one cycle later", {29'd0, dec_valid, dec_dram, dec_mmio}, 32'b110);
    acc_valid = 1'b0;
  endtask

  task automatic t_same_edge;
    logic [2:0] res;
    cfg_write(3'd0, 8'h00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = 3'd0; cfg_wdata = 8'h30;
    acc_valid = 1'b1; acc_addr = 32'hFC000; acc_write = 1'b0;
    @(negedge clk);
    check("R8 same-edge access sees old value", {29'd0, dec_valid, dec_dram, dec_mmio}, 32'b101);
    cfg_we = 1'b0; acc_valid = 1'b0;
    model[0] = 8'h30;
    access(32'hFC000, 1'b0, res);
    check("R8 next access sees new value", {29'd0, res}, 32'b110);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = 8'h00;
    #1 check("R7 outputs low in reset", {29'd0, dec_valid, dec_dram, dec_mmio}, 32'b000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_codes();
    t_top();
    t_sweep(8'h17);
    t_sweep(8'hC9);
    t_reserved();
    t_outside();
    t_timing();
    t_same_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule